// File: doc/BRIEF.md
# Speculative-Data Direct-Mapped Read Cache

This block is a 1 KB direct-mapped cache that sits between a 32-bit load/store port and a single-word lower-level memory port. The capacity is split into 32 lines of 32 bytes. Every access reads the word picked by the index and word-select bits straight out of the data array and presents it on the response. The tag comparison runs alongside that read, not in front of it, so the word is ready no later than the hit flag. A consumer can use the word at once and throw it away when `rsp_hit` comes back low.

On a read miss the block stalls new requests and fetches the whole line, one word per handshake, in ascending order. It then installs the tag, marks the line valid and repeats the response with the hit flag set. Stores use write-through with no-write-allocate. A store that hits also updates the cached word. Every store is passed on to the lower level, and a store miss leaves the cache contents untouched.

Top module: `dm_spec_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req` are 0, and every line is invalid, so the first read to any address misses.
- R2: Address bits [4:0] are the byte offset, [4:2] pick the word in the line, [9:5] pick the line and [31:10] form the 22-bit tag. A hit needs the line's valid bit set and its stored tag equal to the address tag.
- R3: A read accepted on a clock edge (`req_valid` and `req_ready` both 1) gives `rsp_valid`=1 in the next cycle with `rsp_hit`. On a hit `rsp_data` is the addressed word, no lower-level request is made, and the block is ready again one cycle later.
- R4: On a read miss the block issues exactly 8 lower-level reads (`mem_we`=0) to the line's base address plus 4*k, for k=0..7 in that order. `mem_req` and `mem_addr` are held until `mem_ack`.
- R5: In the cycle after the eighth acknowledge, the block repeats the response with `rsp_valid`=1, `rsp_hit`=1 and the requested word as it is in memory.
- R6: `req_ready` stays 0 from acceptance until the access completes, including the whole refill. It returns to 1 in the cycle after the final response.
- R7: A store that hits replaces the cached word, and a later read of that word hits and returns the stored value.
- R8: Every store gives no response. It is forwarded as one lower-level write with `mem_we`=1, the word-aligned address and the store data, with the request raised two cycles after acceptance.
- R9: A store that misses does not allocate, so a later read of the same address misses and refills.
- R10: A read to a line index that holds a different tag replaces that line, so the evicted address misses on its next read.
- R11: On a miss to a valid line, `rsp_data` in the first response cycle is the word held by the line at the same word position (the speculative, stale value).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Byte address of the access |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load response present |
| rsp_data | output | 32 | Indexed word, driven before the hit decision |
| rsp_hit | output | 1 | 1 if the response word is valid for the address |
| mem_req | output | 1 | Lower-level request, held until acknowledged |
| mem_we | output | 1 | Lower-level request is a write |
| mem_addr | output | 32 | Word-aligned lower-level address |
| mem_wdata | output | 32 | Lower-level write data |
| mem_ack | input | 1 | Lower level completes the transfer this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
Some behaviours are checked by assertions on every cycle: the lower-level request holds steady until acknowledged, each refill starts at word 0 of the line, a read miss is always followed by a refill request, the repeated response always reports a hit, and each store reaches the lower port with its data two cycles after acceptance. Other behaviours need the bench's scenarios, because they depend on what the arrays hold. These are the speculative stale word on a conflict miss, the order of the refill addresses, the update of a word by a store hit, no allocation on a store miss, and eviction. The bench sweeps all 32 lines and all 8 word positions under three memory latencies.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_REPLAY,
    ST_WFWD
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 32
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic [$clog2(LINES)-1:0]                       look_idx,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(LINES)-1:0] look_tag,
  input  logic                                           set_en,
  output logic                                           hit
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - $clog2(LINE_BYTES) - IDX_W;

  logic [LINES-1:0] valid_vec;
  logic [TAG_W-1:0] tag_vec [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic             sel;
    assign sel = set_en && (look_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else if (sel) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) t_q <= look_tag;
    end

    assign valid_vec[g] = v_q;
    assign tag_vec[g]   = t_q;
  end

  assign hit = valid_vec[look_idx] && (tag_vec[look_idx] == look_tag);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 32
) (
  input  logic                                          clk,
  input  logic [$clog2(LINES)-1:0]                      idx,
  input  logic [$clog2(LINE_BYTES/(DATA_W/8))-1:0]      rd_wsel,
  output logic [DATA_W-1:0]                             rd_word,
  input  logic                                          wr_en,
  input  logic [$clog2(LINE_BYTES/(DATA_W/8))-1:0]      wr_wsel,
  input  logic [DATA_W-1:0]                             wr_word
);
  localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
  localparam int ENTRIES = LINES * WORDS;

  logic [DATA_W-1:0] arr_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) arr_q[{idx, wr_wsel}] <= wr_word;
  end

  // read path bypasses the tag compare entirely
  assign rd_word = arr_q[{idx, rd_wsel}];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_write,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic                  hit,
  output logic                  rsp_valid,
  output logic [$clog2(LINES)-1:0] look_idx,
  output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(LINES)-1:0] look_tag,
  output logic [$clog2(LINE_BYTES/(DATA_W/8))-1:0] look_wsel,
  output logic                  arr_we,
  output logic [$clog2(LINE_BYTES/(DATA_W/8))-1:0] arr_wsel,
  output logic [DATA_W-1:0]     arr_wdata,
  output logic                  tag_set,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic                  mem_ack,
  input  logic [DATA_W-1:0]     mem_rdata
);
  localparam int BYTE_OFF = $clog2(DATA_W / 8);
  localparam int WORDS    = LINE_BYTES / (DATA_W / 8);
  localparam int WSEL_W   = $clog2(WORDS);
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int IDX_W    = $clog2(LINES);

  dmc_state_e                 state_q, state_d;
  logic [WSEL_W-1:0]          cnt_q, cnt_d;
  logic [ADDR_W-1:BYTE_OFF]   wa_q;
  logic                       wr_q;
  logic [DATA_W-1:0]          wd_q;
  logic                       accept, last_beat;
  logic                       unused_lo;

  assign unused_lo = ^req_addr[BYTE_OFF-1:0];
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign last_beat = (cnt_q == WSEL_W'(WORDS - 1));

  assign look_idx  = wa_q[OFF_W+IDX_W-1:OFF_W];
  assign look_tag  = wa_q[ADDR_W-1:OFF_W+IDX_W];
  assign look_wsel = wa_q[OFF_W-1:BYTE_OFF];

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_LOOK;
      ST_LOOK: begin
        if (wr_q)     state_d = ST_WFWD;
        else if (hit) state_d = ST_IDLE;
        else begin
          state_d = ST_FILL;
          cnt_d   = '0;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (last_beat) state_d = ST_REPLAY;
        end
      end
      ST_REPLAY: state_d = ST_IDLE;
      ST_WFWD:   if (mem_ack) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      wa_q <= req_addr[ADDR_W-1:BYTE_OFF];
      wr_q <= req_write;
      wd_q <= req_wdata;
    end
  end

  // array and port drive
  assign rsp_valid = ((state_q == ST_LOOK) && !wr_q) || (state_q == ST_REPLAY);
  assign arr_we    = ((state_q == ST_FILL) && mem_ack) ||
                     ((state_q == ST_LOOK) && wr_q && hit);
  assign arr_wsel  = (state_q == ST_FILL) ? cnt_q : look_wsel;
  assign arr_wdata = (state_q == ST_FILL) ? mem_rdata : wd_q;
  assign tag_set   = (state_q == ST_FILL) && mem_ack && last_beat;

  assign mem_req   = (state_q == ST_FILL) || (state_q == ST_WFWD);
  assign mem_we    = (state_q == ST_WFWD);
  assign mem_addr  = (state_q == ST_FILL)
                   ? {wa_q[ADDR_W-1:OFF_W], cnt_q, {BYTE_OFF{1'b0}}}
                   : {wa_q, {BYTE_OFF{1'b0}}};
  assign mem_wdata = wd_q;

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R4
  fill_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && !mem_we |-> mem_addr[OFF_W-1:0] == '0);
  // R3
  miss_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !hit |=> mem_req && !mem_we);
  // R5
  replay_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_REPLAY |-> hit);
  // R8
  store_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write |=> ##1 (mem_req && mem_we && mem_wdata == $past(req_wdata, 2)));
endmodule

// File: rtl/dm_spec_cache.sv
module dm_spec_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int WSEL_W = $clog2(LINE_BYTES / (DATA_W / 8));
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - $clog2(LINE_BYTES) - IDX_W;

  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic [WSEL_W-1:0] look_wsel, arr_wsel;
  logic              arr_we, tag_set, hit;
  logic [DATA_W-1:0] arr_wdata;

  dmc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .LINES(LINES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata),
    .hit(hit), .rsp_valid(rsp_valid),
    .look_idx(look_idx), .look_tag(look_tag), .look_wsel(look_wsel),
    .arr_we(arr_we), .arr_wsel(arr_wsel), .arr_wdata(arr_wdata), .tag_set(tag_set),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  dmc_tag_store #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LINES(LINES)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .look_idx(look_idx), .look_tag(look_tag), .set_en(tag_set), .hit(hit)
  );

  dmc_data_store #(.DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .LINES(LINES)) u_data (
    .clk(clk), .idx(look_idx), .rd_wsel(look_wsel), .rd_word(rsp_data),
    .wr_en(arr_we), .wr_wsel(arr_wsel), .wr_word(arr_wdata)
  );

  assign rsp_hit = hit;
endmodule

// File: tb/dm_spec_cache_bench.sv
`timescale 1ns/100ps
module dm_spec_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        req_ready, rsp_valid, rsp_hit;
  logic [31:0] rsp_data;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  always #2.5 clk = ~clk;

  dm_spec_cache u_dm_spec_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int  checks = 0;
  int  fails  = 0;
  int  cyc    = 0;
  bit  done   = 0;
  always @(posedge clk) cyc++;

  // lower-level memory model: arithmetic contents plus stored overrides
  logic [31:0] ov [logic [31:0]];
  function automatic logic [31:0] mval(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    if (ov.exists(w)) return ov[w];
    return (w * 32'h0001_0003) ^ 32'h5A5A_1234;
  endfunction

  int          lat = 0;
  int          wcnt = 0;
  int          lg_n = 0;
  int          last_cyc = -1;
  logic [31:0] lg_addr [16];
  logic        lg_we   [16];
  logic [31:0] lg_wd   [16];
  logic [31:0] p_addr, p_wd;
  logic        p_we;

  always @(negedge clk) begin
    if (mem_ack) begin
      if (lg_n < 16) begin
        lg_addr[lg_n] = p_addr; lg_we[lg_n] = p_we; lg_wd[lg_n] = p_wd;
      end
      lg_n++;
      last_cyc = cyc;
      if (p_we) ov[{p_addr[31:2], 2'b00}] = p_wd;
    end
    if (mem_req && rst_n) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1; mem_rdata = mval(mem_addr);
        p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata;
        wcnt = 0;
      end else begin
        mem_ack = 1'b0; wcnt++;
      end
    end else begin
      mem_ack = 1'b0; wcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  bit          sv [32];
  logic [21:0] st [32];

  task automatic do_read(input logic [31:0] a, input string miss_tag);
    int idx; logic [21:0] tg; bit eh; int n; bit rdy;
    idx = int'(a[9:5]); tg = a[31:10];
    eh  = sv[idx] && (st[idx] == tg);
    @(negedge clk); #1;
    req_valid = 1; req_write = 0; req_addr = a; lg_n = 0;
    @(posedge clk);
    @(negedge clk); #1;
    req_valid = 0;
    chk(rsp_valid == 1'b1, "R3", "response after accept", 32'(rsp_valid), 1);
    chk(req_ready == 1'b0, "R6", "busy during lookup", 32'(req_ready), 0);
    chk(rsp_hit == eh, eh ? "R2" : miss_tag, "hit flag", 32'(rsp_hit), 32'(eh));
    if (eh) chk(rsp_data == mval(a), "R3", "hit data", rsp_data, mval(a));
    else if (sv[idx])
      chk(rsp_data == mval({st[idx], a[9:0]}), "R11", "speculative stale word",
          rsp_data, mval({st[idx], a[9:0]}));
    if (!eh) begin
      n = 0; rdy = 0;
      do begin
        @(negedge clk); #1; n++;
        if (req_ready) rdy = 1;
      end while (!rsp_valid && n < 200);
      chk(!rdy, "R6", "ready low during refill", 32'(rdy), 0);
      chk(rsp_valid && rsp_hit, "R5", "replay with hit", 32'(rsp_hit), 1);
      chk(rsp_data == mval(a), "R5", "replay data", rsp_data, mval(a));
      chk(last_cyc == cyc, "R5", "replay right after last beat", 32'(last_cyc), 32'(cyc));
      chk(lg_n == 8, "R4", "refill beats", 32'(lg_n), 8);
      for (int k = 0; k < 8; k++)
        chk(lg_addr[k] == {a[31:5], 3'(k), 2'b00} && !lg_we[k], "R4", "refill address",
            lg_addr[k], {a[31:5], 3'(k), 2'b00});
      sv[idx] = 1; st[idx] = tg;
    end else begin
      chk(lg_n == 0 && !mem_req, "R3", "no traffic on hit", 32'(lg_n), 0);
    end
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R6", "ready after completion", 32'(req_ready), 1);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    int n;
    @(negedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; lg_n = 0;
    @(posedge clk);
    @(negedge clk); #1;
    req_valid = 0;
    chk(rsp_valid == 1'b0, "R8", "store gives no response", 32'(rsp_valid), 0);
    n = 0;
    while (!req_ready && n < 200) begin @(negedge clk); #1; n++; end
    chk(lg_n == 1 && lg_we[0], "R8", "one forwarded write", 32'(lg_n), 1);
    chk(lg_addr[0] == {a[31:2], 2'b00}, "R8", "forward address", lg_addr[0], {a[31:2], 2'b00});
    chk(lg_wd[0] == d, "R8", "forward data", lg_wd[0], d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [21:0] t1, t2;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    mem_ack = 0; mem_rdata = '0;
    for (int p = 0; p < 3; p++) begin
      lat = p;
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      rst_n = 1;
      for (int i = 0; i < 32; i++) sv[i] = 0;
      @(negedge clk); #1;
      // R1 reset state
      chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
      chk(rsp_valid == 1'b0, "R1", "no response after reset", 32'(rsp_valid), 0);
      chk(mem_req == 1'b0, "R1", "no memory request after reset", 32'(mem_req), 0);
      t1 = 22'h0ABC0 + 22'(p);
      t2 = t1 ^ 22'h2D5A5;
      // first touch of every line misses (R1), all words then hit (R3)
      for (int i = 0; i < 32; i++) do_read({t1, 5'(i), 3'(i), 2'b00}, "R1");
      for (int i = 0; i < 32; i++)
        for (int w = 0; w < 8; w++) do_read({t1, 5'(i), 3'(w), 2'b00}, "R3");
      // store hits update the line (R7)
      for (int i = 0; i < 32; i += 5) begin
        do_write({t1, 5'(i), 3'(7 - i % 8), 2'b01}, 32'hC0DE_0000 + 32'(i * 97 + p));
        do_read({t1, 5'(i), 3'(7 - i % 8), 2'b00}, "R7");
      end
      // store misses do not allocate (R9)
      for (int i = 1; i < 32; i += 7) begin
        do_write({t2, 5'(i), 3'(i % 8), 2'b10}, 32'hBEEF_0000 + 32'(i + p));
        do_read({t2, 5'(i), 3'(i % 8), 2'b00}, "R9");
      end
      // conflict eviction with stale speculative word (R10, R11)
      for (int i = 0; i < 32; i++) begin
        do_read({t2, 5'(i), 3'(i % 8), 2'b00}, "R11");
        do_read({t1, 5'(i), 3'(i % 8), 2'b00}, "R10");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule